// File: doc/BRIEF.md
# Serial ADC Device-Side Transfer Front End

This block is the digital side of a serial, multiplexed 10-bit converter as seen from the device pins. A host lowers a chip-select line and toggles an I/O clock. On the first rising clock edges it shifts in a 4-bit channel code, most significant bit first. On every falling edge it shifts out the result of the conversion before, also most significant bit first. The block counts falling clock edges and uses the count to drive the analog front end. A sample-start strobe and a sampling level begin at one edge count. A hold strobe at a later edge count ends the sampling window and starts the conversion.

A behavioural converter model stands in for the analog core. It keeps end-of-conversion low for a fixed number of internal cycles. It then latches a new result word. For external channels the word comes from an input port. Three internal test channels return fixed codes, and the two codes left over return zero. All pin inputs pass through a two-flop synchronizer on the fast internal clock. The host may raise chip select between transfers. It may instead hold chip select low and run back-to-back 16-clock transfers, and in that case the 16th falling edge begins the next sequence.

Top module: `sadc_frontend`

## Requirements
- R1: After reset, dout_en is 0, dout is 0, eoc is 1, sampling is 0, ch_sel is 0, and the stored result is 0.
- R2: The channel code is taken from addr_in on the first four rising io_clk edges of a sequence, first bit as the code's MSB. Further rising edges leave it unchanged. ch_sel takes the code at the 4th falling edge.
- R3: sample_start pulses for one clock after the 4th falling io_clk edge of a sequence. sampling is 1 from that pulse until the 10th falling edge.
- R4: The 10th falling io_clk edge gives a one-clock hold_strobe pulse, clears sampling and starts a conversion: eoc goes 0.
- R5: eoc stays 0 for exactly CONV_CYCLES clocks. It returns to 1 in the same cycle that the new result is latched.
- R6: While chip select is low, dout shows the stored result MSB first and moves one bit on each falling io_clk edge. After 10 bits it is 0 for the rest of a 16-clock transfer. For channels 0 to 10 the result is the conv_in value.
- R7: dout_en is 1 while cs_n is low and 0 while cs_n is high. io_clk and addr_in activity while cs_n is high causes no strobes and does not change ch_sel.
- R8: With cs_n held low, the 16th falling io_clk edge starts a new sequence. dout then shows the MSB of the latest result, and the next four rising edges load a new channel code.
- R9: Channel codes 11, 12 and 13 convert to 512, 0 and 1023 respectively, whatever conv_in holds.
- R10: Channel codes 14 and 15 convert to 0. The transfer and the conversion complete normally.
- R11: A rising cs_n edge in the middle of a sequence clears sampling and starts no conversion. The next falling cs_n edge restarts the edge counts and the data from the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, faster than io_clk |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous to clk |
| io_clk | input | 1 | Host serial transfer clock |
| addr_in | input | 1 | Serial channel code from the host |
| conv_in | input | 10 | Result word for external channels |
| dout | output | 1 | Serial result bit |
| dout_en | output | 1 | Output drive enable (0 means high impedance) |
| sample_start | output | 1 | One-clock pulse at the start of sampling |
| sampling | output | 1 | High during the sampling window |
| hold_strobe | output | 1 | One-clock pulse when the sample is held |
| ch_sel | output | 4 | Channel code of the current sample |
| eoc | output | 1 | End of conversion, low while converting |

## Verification
The assertions assume that each io_clk phase lasts several internal clocks, so that every pin edge gets through the synchronizer as its own event. They also assume that addr_in is settled before each rising io_clk edge and that conv_in stays steady while a conversion runs. They further assume that no new 10th falling edge arrives while a conversion is still busy. The bench drives each io_clk phase for 8 clocks and changes addr_in only in the low phase. It holds conv_in from before a transfer until eoc returns high, and it waits for eoc before it starts the next transfer.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int RES_W       = 10;
    localparam int ADDR_W      = 4;
    localparam int XFER_LEN    = 16;
    localparam int SAMPLE_EDGE = 4;
    localparam int HOLD_EDGE   = 10;
    localparam int EXT_CH      = 11;
    localparam int TEST_CH     = 3;
    localparam int CONV_CYCLES = 40;
    localparam int SYNC_STAGES = 2;

    localparam int CNT_W = $clog2(XFER_LEN + 1);
    localparam int IDX_W = $clog2(RES_W + 1);

    typedef logic [RES_W-1:0]  word_t;
    typedef logic [ADDR_W-1:0] chan_t;

    typedef enum logic [1:0] {
        CH_EXT,
        CH_TEST,
        CH_UNDEF
    } ch_kind_e;

    function automatic ch_kind_e classify(chan_t c);
        if (c < chan_t'(EXT_CH))
            return CH_EXT;
        else if (c < chan_t'(EXT_CH + TEST_CH))
            return CH_TEST;
        else
            return CH_UNDEF;
    endfunction

    function automatic word_t test_code(chan_t c);
        chan_t k;
        k = c - chan_t'(EXT_CH);
        case (k)
            chan_t'(0): return {1'b1, {(RES_W-1){1'b0}}};
            chan_t'(1): return '0;
            default:    return '1;
        endcase
    endfunction

    function automatic word_t pick_result(chan_t c, word_t ext);
        case (classify(c))
            CH_EXT:  return ext;
            CH_TEST: return test_code(c);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/sadc_sync_edge.sv
module sadc_sync_edge #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] sh;
        logic              prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                sh   <= {STAGES{RST_VAL[b]}};
                prev <= RST_VAL[b];
            end else begin
                sh   <= {sh[STAGES-2:0], async_in[b]};
                prev <= sh[STAGES-1];
            end
        end

        assign lvl[b]  = sh[STAGES-1];
        assign rise[b] = sh[STAGES-1] & ~prev;
        assign fall[b] = ~sh[STAGES-1] & prev;
    end

endmodule

// File: rtl/sadc_seq_ctrl.sv
module sadc_seq_ctrl
    import sadc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  cs_fall,
    input  logic  cs_rise,
    input  logic  clk_rise,
    input  logic  clk_fall,
    input  logic  addr_bit,
    output logic  seq_start,
    output logic  shift_adv,
    output logic  sample_start,
    output logic  sampling,
    output logic  hold_strobe,
    output chan_t ch_sel
);

    localparam int RC_W = $clog2(ADDR_W + 1);
    localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(XFER_LEN - 1);
    localparam logic [CNT_W-1:0] SAMPLE_AT = CNT_W'(SAMPLE_EDGE);
    localparam logic [CNT_W-1:0] HOLD_AT   = CNT_W'(HOLD_EDGE);
    localparam logic [RC_W-1:0]  ADDR_LEN  = RC_W'(ADDR_W);

    logic [CNT_W-1:0] fall_cnt;
    logic [CNT_W-1:0] next_fall;
    logic [RC_W-1:0]  rise_cnt;
    chan_t            addr_sh;
    logic             fall_ev;
    logic             rise_ev;
    logic             wrap;

    always_comb begin
        fall_ev   = active && clk_fall;
        rise_ev   = active && clk_rise;
        wrap      = fall_ev && (fall_cnt == LAST_FALL);
        next_fall = fall_cnt + 1'b1;
        seq_start = cs_fall || wrap;
        shift_adv = fall_ev && !wrap && !cs_fall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fall_cnt     <= '0;
            rise_cnt     <= '0;
            addr_sh      <= '0;
            ch_sel       <= '0;
            sample_start <= 1'b0;
            hold_strobe  <= 1'b0;
            sampling     <= 1'b0;
        end else begin
            sample_start <= 1'b0;
            hold_strobe  <= 1'b0;
            if (cs_fall) begin
                fall_cnt <= '0;
                rise_cnt <= '0;
                sampling <= 1'b0;
            end else if (cs_rise) begin
                sampling <= 1'b0;
            end else begin
                if (rise_ev && (rise_cnt < ADDR_LEN)) begin
                    addr_sh  <= {addr_sh[ADDR_W-2:0], addr_bit};
                    rise_cnt <= rise_cnt + 1'b1;
                end
                if (fall_ev) begin
                    if (wrap) begin
                        fall_cnt <= '0;
                        rise_cnt <= '0;
                    end else begin
                        fall_cnt <= next_fall;
                    end
                    if (!wrap && next_fall == SAMPLE_AT) begin
                        sample_start <= 1'b1;
                        sampling     <= 1'b1;
                        ch_sel       <= addr_sh;
                    end
                    if (!wrap && next_fall == HOLD_AT) begin
                        hold_strobe <= 1'b1;
                        sampling    <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sadc_conv_model.sv
module sadc_conv_model
    import sadc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  chan_t ch_sel,
    input  word_t conv_in,
    output logic  eoc,
    output word_t result
);

    localparam int CW = $clog2(CONV_CYCLES + 1);

    logic          busy;
    logic [CW-1:0] cnt;
    chan_t         chan_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            chan_q <= '0;
            result <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                cnt    <= CW'(CONV_CYCLES - 1);
                chan_q <= ch_sel;
            end
        end else if (cnt == '0) begin
            busy   <= 1'b0;
            result <= pick_result(chan_q, conv_in);
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign eoc = !busy;

endmodule

// File: rtl/sadc_out_shift.sv
module sadc_out_shift
    import sadc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  seq_start,
    input  logic  shift_adv,
    input  word_t result,
    output logic  dout,
    output logic  dout_en
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(RES_W - 1);
    localparam logic [IDX_W-1:0] DONE = IDX_W'(RES_W);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (seq_start)
            idx <= '0;
        else if (shift_adv && idx != DONE)
            idx <= idx + 1'b1;
    end

    always_comb begin
        pos     = LAST - idx;
        dout_en = active;
        dout    = (active && idx <= LAST) ? result[pos] : 1'b0;
    end

endmodule

// File: rtl/sadc_frontend.sv
module sadc_frontend
    import sadc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             io_clk,
    input  logic             addr_in,
    input  logic [RES_W-1:0] conv_in,
    output logic             dout,
    output logic             dout_en,
    output logic             sample_start,
    output logic             sampling,
    output logic             hold_strobe,
    output logic [ADDR_W-1:0] ch_sel,
    output logic             eoc
);

    localparam int PIN_CS   = 2;
    localparam int PIN_CLK  = 1;
    localparam int PIN_ADDR = 0;

    logic [2:0] s_lvl;
    logic [2:0] s_rise;
    logic [2:0] s_fall;
    logic       active;
    logic       seq_start;
    logic       shift_adv;
    word_t      result;
    logic       sync_unused;

    sadc_sync_edge #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({cs_n, io_clk, addr_in}),
        .lvl      (s_lvl),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    assign active      = !s_lvl[PIN_CS];
    assign sync_unused = &{1'b0, s_lvl[PIN_CLK], s_rise[PIN_ADDR], s_fall[PIN_ADDR]};

    sadc_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .active       (active),
        .cs_fall      (s_fall[PIN_CS]),
        .cs_rise      (s_rise[PIN_CS]),
        .clk_rise     (s_rise[PIN_CLK]),
        .clk_fall     (s_fall[PIN_CLK]),
        .addr_bit     (s_lvl[PIN_ADDR]),
        .seq_start    (seq_start),
        .shift_adv    (shift_adv),
        .sample_start (sample_start),
        .sampling     (sampling),
        .hold_strobe  (hold_strobe),
        .ch_sel       (ch_sel)
    );

    sadc_conv_model u_conv (
        .clk     (clk),
        .rst     (rst),
        .start   (hold_strobe),
        .ch_sel  (ch_sel),
        .conv_in (conv_in),
        .eoc     (eoc),
        .result  (result)
    );

    sadc_out_shift u_out (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .seq_start (seq_start),
        .shift_adv (shift_adv),
        .result    (result),
        .dout      (dout),
        .dout_en   (dout_en)
    );

endmodule

// File: rtl/sadc_frontend_chk.sv
module sadc_frontend_chk
    import sadc_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sample_start,
    input logic sampling,
    input logic hold_strobe,
    input logic eoc,
    input logic dout_en
);

    logic [15:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            low_cnt <= '0;
        else if (eoc)
            low_cnt <= '0;
        else
            low_cnt <= low_cnt + 1'b1;
    end

    AST_SAMPLE_OPENS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        sample_start |-> sampling); // R3

    AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sample_start, hold_strobe})); // R3

    AST_HOLD_CLOSES_WINDOW: assert property (@(posedge clk) disable iff (rst)
        hold_strobe |-> (!sampling && $past(sampling))); // R4

    AST_HOLD_STARTS_CONV: assert property (@(posedge clk) disable iff (rst)
        (hold_strobe && eoc) |=> !eoc); // R4

    AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $rose(eoc) |-> (low_cnt == 16'(CONV_CYCLES))); // R5

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !dout_en); // R7

endmodule

bind sadc_frontend sadc_frontend_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_n         (cs_n),
    .sample_start (sample_start),
    .sampling     (sampling),
    .hold_strobe  (hold_strobe),
    .eoc          (eoc),
    .dout_en      (dout_en)
);

// File: tb/sadc_frontend_tb_top.sv
module sadc_frontend_tb_top;
    import sadc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        io_clk = 1'b0;
    logic        addr_in = 1'b0;
    logic [9:0]  conv_in = '0;
    logic        dout, dout_en, sample_start, sampling, hold_strobe, eoc;
    logic [3:0]  ch_sel;

    int errors = 0;
    int checks = 0;
    int n_samp = 0;
    int n_hold = 0;
    int low_run = 0;
    int last_low = 0;

    always #5 clk = ~clk;

    sadc_frontend dut_i (
        .clk (clk), .rst (rst), .cs_n (cs_n), .io_clk (io_clk), .addr_in (addr_in),
        .conv_in (conv_in), .dout (dout), .dout_en (dout_en),
        .sample_start (sample_start), .sampling (sampling),
        .hold_strobe (hold_strobe), .ch_sel (ch_sel), .eoc (eoc)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (sample_start) n_samp++;
            if (hold_strobe)  n_hold++;
            if (!eoc) low_run++;
            else if (low_run != 0) begin
                last_low = low_run;
                low_run  = 0;
            end
        end
    end

    localparam int NV = 7;
    localparam logic [3:0] VA  [NV] = '{4'd3, 4'd11, 4'd12, 4'd13, 4'd14, 4'd7, 4'd0};
    localparam logic [9:0] VR  [NV] = '{10'h2A5, 10'h111, 10'h111, 10'h111, 10'h2AA, 10'h155, 10'h3FF};
    localparam logic [9:0] EXP [NV] = '{10'h2A5, 10'h200, 10'h000, 10'h3FF, 10'h000, 10'h155, 10'h3FF};

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic xfer(input logic [3:0] a, input bit drop_cs, input bit conv_ok, output logic [15:0] cap);
        if (drop_cs) begin
            cs_n = 1'b0;
            wait_n(10);
            chk(dout_en === 1'b1, "R7", 32'(dout_en), 1);
        end
        for (int k = 0; k < 16; k++) begin
            addr_in = (k < 4) ? a[3-k] : ~a[0];
            wait_n(8);
            io_clk = 1'b1;
            wait_n(8);
            cap[15-k] = dout;
            if (k >= 3 && k <= 10)
                chk(sampling === (k >= 4 && k < 10), "R3", 32'(sampling), 32'(k >= 4 && k < 10));
            if (k == 10 && conv_ok)
                chk(eoc === 1'b0, "R4", 32'(eoc), 0);
            io_clk = 1'b0;
        end
        wait_n(8);
        if (drop_cs) begin
            cs_n = 1'b1;
            wait_n(6);
            chk(dout_en === 1'b0, "R7", 32'(dout_en), 0);
        end
    endtask

    task automatic wait_eoc();
        for (int t = 0; t < 300 && eoc !== 1'b1; t++) wait_n(1);
        wait_n(4);
        chk(eoc === 1'b1, "R5", 32'(eoc), 1);
    endtask

    function automatic string tag_for(input logic [3:0] c);
        if (c >= 4'd14) return "R10";
        if (c >= 4'd11) return "R9";
        return "R6";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] cap;
        int s0, h0;
        logic [3:0] ch0;

        wait_n(6);
        rst = 1'b0;
        wait_n(4);
        chk(dout_en === 1'b0, "R1", 32'(dout_en), 0);
        chk(dout === 1'b0, "R1", 32'(dout), 0);
        chk(eoc === 1'b1, "R1", 32'(eoc), 1);
        chk(sampling === 1'b0, "R1", 32'(sampling), 0);
        chk(ch_sel === 4'd0, "R1", 32'(ch_sel), 0);

        // table walk, chip select toggled around every transfer
        for (int i = 0; i < NV; i++) begin
            conv_in = VR[i];
            xfer(VA[i], 1'b1, 1'b1, cap);
            if (i == 0)
                chk(cap === 16'h0000, "R1", 32'(cap), 0);
            else
                chk(cap[15:6] === EXP[i-1], tag_for(VA[i-1]), 32'(cap[15:6]), 32'(EXP[i-1]));
            chk(cap[5:0] === 6'b0, "R6", 32'(cap[5:0]), 0);
            chk(ch_sel === VA[i], "R2", 32'(ch_sel), 32'(VA[i]));
            wait_eoc();
            chk(last_low == CONV_CYCLES, "R5", 32'(last_low), 32'(CONV_CYCLES));
            wait_n(10);
        end

        conv_in = 10'h0F0;
        xfer(4'd5, 1'b1, 1'b1, cap);
        chk(cap[15:6] === EXP[NV-1], "R6", 32'(cap[15:6]), 32'(EXP[NV-1]));
        chk(ch_sel === 4'd5, "R2", 32'(ch_sel), 5);
        wait_eoc();

        // chip select held low for two back-to-back transfers
        conv_in = 10'h333;
        cs_n = 1'b0;
        wait_n(10);
        xfer(4'd9, 1'b0, 1'b1, cap);
        chk(cap[15:6] === 10'h0F0, "R8", 32'(cap[15:6]), 32'h0F0);
        wait_eoc();
        chk(dout === 1'b1, "R8", 32'(dout), 1);
        chk(dout_en === 1'b1, "R8", 32'(dout_en), 1);
        conv_in = 10'h055;
        xfer(4'd11, 1'b0, 1'b1, cap);
        chk(cap[15:6] === 10'h333, "R8", 32'(cap[15:6]), 32'h333);
        chk(ch_sel === 4'd11, "R8", 32'(ch_sel), 11);
        wait_eoc();
        cs_n = 1'b1;
        wait_n(10);

        // io_clk and addr_in toggled while deselected
        s0 = n_samp; h0 = n_hold; ch0 = ch_sel;
        for (int k = 0; k < 12; k++) begin
            addr_in = 1'b1;
            wait_n(8); io_clk = 1'b1; wait_n(8); io_clk = 1'b0;
        end
        wait_n(10);
        chk(n_samp == s0 && n_hold == h0, "R7", 32'(n_samp - s0 + n_hold - h0), 0);
        chk(ch_sel === ch0, "R7", 32'(ch_sel), 32'(ch0));
        chk(dout_en === 1'b0, "R7", 32'(dout_en), 0);
        chk(eoc === 1'b1, "R7", 32'(eoc), 1);

        // aborted transfer after six clocks, then a full one
        s0 = n_samp; h0 = n_hold;
        cs_n = 1'b0;
        wait_n(10);
        for (int k = 0; k < 6; k++) begin
            addr_in = (k < 4) ? 4'b0110 >> (3 - k) : 1'b0;
            wait_n(8); io_clk = 1'b1; wait_n(8); io_clk = 1'b0;
        end
        wait_n(8);
        cs_n = 1'b1;
        wait_n(10);
        chk(n_samp == s0 + 1, "R11", 32'(n_samp - s0), 1);
        chk(n_hold == h0, "R11", 32'(n_hold - h0), 0);
        chk(sampling === 1'b0, "R11", 32'(sampling), 0);
        chk(eoc === 1'b1, "R11", 32'(eoc), 1);
        conv_in = 10'h0AB;
        xfer(4'd2, 1'b1, 1'b1, cap);
        chk(cap[15:6] === 10'h200, "R11", 32'(cap[15:6]), 32'h200);
        chk(ch_sel === 4'd2, "R11", 32'(ch_sel), 2);
        chk(n_hold == h0 + 1, "R11", 32'(n_hold - h0), 1);
        wait_eoc();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule